// File: doc/BRIEF.md
# Hybrid Self-Mapping Retry Controller

This block sequences the self-mapping of a reconfigurable crossbar that may have defects. It starts in a cheap mode. Each attempt loads a whole configuration drawn from a pseudo-random generator and then runs an application-level self-test. A failing test leads straight to another random configuration, and no diagnosis is done. Once a programmable number of these random attempts has failed, the controller changes strategy by itself. In the second mode, every failing test is followed by a diagnosis of the resources the current configuration uses. After that, a partial reload swaps out only the flagged resources, and the test runs again.

The loader, the tester and the diagnosis engine sit outside the block. Each one is driven through a request line that stays high until that unit raises its one-cycle done. Mapping ends when a test passes in either mode. It also ends when the total number of failed tests reaches an overall cap. The controller then reports the outcome, how many tests failed, and whether it finished in the random or the guided mode.

Top module: `selfmap_ctrl`

## Requirements
- R1: After reset the controller is idle. All three request lines, `busy`, `map_ok`, `map_fail` and `ended_guided` are low, `fail_count` is 0 and `cfg_rand` is 16'hACE1.
- R2: The random source is a 16-bit shift register. It shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It advances exactly once on each entry into a configuration request, so `cfg_rand` already holds the advanced value during the first cycle of that request. A `go` pulse in an idle or finished state opens a configuration request with `cfg_partial` low.
- R3: At most one of `cfg_req`, `test_req` and `diag_req` is high at a time. Each request stays high until its done input is sampled high. `test_pass` is read only in the cycle in which `test_done` is high.
- R4: In random mode, a failing test that neither exhausts the cap nor the budget leads directly to a new full configuration request (`cfg_partial` low) with a fresh random value, and no diagnosis request is raised.
- R5: Once the number of failed random-mode tests reaches `rand_budget`, the next step is a diagnosis request. A budget of 0 behaves like 1. Guided mode then repeats this cycle: diagnosis request, then partial configuration request (`cfg_partial` high, fresh random value), then test request.
- R6: A passing test in either mode ends mapping with `map_ok` high and `busy` low. `ended_guided` is 1 if guided mode was reached and 0 otherwise.
- R7: `fail_count` counts failed tests in both modes. When a failed test makes it equal `fail_cap`, mapping ends with `map_fail`. A cap of 0 behaves like 1. The cap takes precedence over the switch to guided mode.
- R8: `seed_load` with `seed_val` replaces the random state only while the controller is not busy, and a zero seed is stored as 16'h0001. While busy, `seed_load` has no effect.
- R9: A `go` pulse in a finished state restarts mapping from random mode, with `fail_count` cleared and `ended_guided` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start or restart mapping when not busy |
| seed_load | input | 1 | Load the random state from `seed_val` when not busy |
| seed_val | input | 16 | Seed value |
| rand_budget | input | CNT_W | Failed random attempts before guided mode |
| fail_cap | input | CNT_W | Total failed tests that end mapping with failure |
| cfg_req | output | 1 | Configuration load request |
| cfg_partial | output | 1 | 1: replace flagged resources only, 0: full load |
| cfg_rand | output | 16 | Random bits for the loader |
| cfg_done | input | 1 | Loader finished |
| test_req | output | 1 | Self-test request |
| test_done | input | 1 | Self-test finished |
| test_pass | input | 1 | Self-test verdict, valid with `test_done` |
| diag_req | output | 1 | Diagnosis request |
| diag_done | input | 1 | Diagnosis finished |
| busy | output | 1 | Mapping in progress |
| map_ok | output | 1 | Mapping ended with a passing test |
| map_fail | output | 1 | Mapping ended at the failure cap |
| ended_guided | output | 1 | Guided mode was reached in this run |
| fail_count | output | CNT_W | Failed tests in this run |

## Verification
The bench targets the mode switch at the exact budget. A controller that is off by one would raise a diagnosis request one attempt early or late, or would diagnose while still in random mode. It also sets the cap equal to the budget. A design that checks the budget before the cap would start diagnosis instead of reporting failure. Other cases are a zero budget, a zero seed, a seed load during a run, which a careless design would apply and so corrupt the next random value, and a restart from a finished state, which must clear the failure count and the mode flag.

// File: rtl/selfmap_pkg.sv
// Shared types and constants of the self-mapping controller.
// Assumes: a 16-bit random source; the states below are the only ones.
package selfmap_pkg;
    localparam int RND_W = 16;
    localparam logic [RND_W-1:0] RND_RESET = 16'hACE1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAND_CFG,
        ST_RAND_TEST,
        ST_GUIDE_DIAG,
        ST_GUIDE_CFG,
        ST_GUIDE_TEST,
        ST_END_OK,
        ST_END_FAIL
    } map_state_t;
endpackage

// File: rtl/selfmap_rng.sv
// Random source for configuration bits: a 16-bit maximal-length shift register.
// Assumes: the caller never asks to step and to load in the same cycle (step wins).
module selfmap_rng
    import selfmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [RND_W-1:0] seed,
    output logic [RND_W-1:0] value
);
    logic [RND_W-1:0] state_q;
    logic             fb;

    // Feedback bit of the x^16+x^14+x^13+x^11+1 polynomial.
    always_comb fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

    // State update: reset value, one shift per step, or a seed (zero mapped to 1).
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RND_RESET;
        else if (step)
            state_q <= {state_q[RND_W-2:0], fb};
        else if (load)
            state_q <= (seed == '0) ? {{(RND_W-1){1'b0}}, 1'b1} : seed;
    end

    assign value = state_q;

    assert_rng_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (value != '0));
    assert_rng_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (value[RND_W-1:1] == $past(value[RND_W-2:0])));
endmodule

// File: rtl/selfmap_tally.sv
// Failure counters: total failed tests and failed random-mode tests.
// Reports, for the failure being counted now, whether it reaches the cap or the budget.
// Assumes: a limit of 0 is treated as 1; counters saturate at their maximum.
module selfmap_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_total,
    input  logic             inc_rand,
    input  logic [CNT_W-1:0] cap,
    input  logic [CNT_W-1:0] budget,
    output logic [CNT_W-1:0] total,
    output logic             cap_reached,
    output logic             budget_reached
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W:0]   ONE_W   = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] rand_q;
    logic [CNT_W:0]   cap_eff;
    logic [CNT_W:0]   budget_eff;

    // Effective limits with zero promoted to one.
    always_comb begin
        cap_eff    = (cap == '0)    ? ONE_W : {1'b0, cap};
        budget_eff = (budget == '0) ? ONE_W : {1'b0, budget};
    end

    // Limit compares against the count including the current failure.
    always_comb begin
        cap_reached    = ({1'b0, total_q} + ONE_W) >= cap_eff;
        budget_reached = ({1'b0, rand_q} + ONE_W) >= budget_eff;
    end

    // Total failed-test counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            total_q <= '0;
        else if (inc_total && total_q != CNT_MAX)
            total_q <= total_q + 1'b1;
    end

    // Random-mode failed-test counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            rand_q <= '0;
        else if (inc_rand && rand_q != CNT_MAX)
            rand_q <= rand_q + 1'b1;
    end

    assign total = total_q;

    assert_total_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_total && !clr && total_q != CNT_MAX) |=> (total_q == $past(total_q) + 1'b1));
    assert_total_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total_q == '0));
endmodule

// File: rtl/selfmap_seq.sv
// Mapping sequencer: random retries first, then diagnosis-guided partial reloads.
// Assumes: done inputs are single-cycle pulses answering the active request only.
module selfmap_seq
    import selfmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cfg_done,
    input  logic test_done,
    input  logic test_pass,
    input  logic diag_done,
    input  logic cap_reached,
    input  logic budget_reached,
    output logic cfg_req,
    output logic cfg_partial,
    output logic test_req,
    output logic diag_req,
    output logic cnt_clr,
    output logic inc_total,
    output logic inc_rand,
    output logic rng_step,
    output logic busy,
    output logic map_ok,
    output logic map_fail,
    output logic guided
);
    map_state_t state_q, state_d;
    logic       guided_q;
    logic       accept_go;
    logic       test_fail;

    // Strobes derived from the current state and handshakes.
    always_comb begin
        accept_go = go && (state_q == ST_IDLE || state_q == ST_END_OK || state_q == ST_END_FAIL);
        test_fail = test_done && !test_pass &&
                    (state_q == ST_RAND_TEST || state_q == ST_GUIDE_TEST);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_END_OK, ST_END_FAIL:
                if (go) state_d = ST_RAND_CFG;
            ST_RAND_CFG:
                if (cfg_done) state_d = ST_RAND_TEST;
            ST_RAND_TEST:
                if (test_done) begin
                    if (test_pass)           state_d = ST_END_OK;
                    else if (cap_reached)    state_d = ST_END_FAIL;
                    else if (budget_reached) state_d = ST_GUIDE_DIAG;
                    else                     state_d = ST_RAND_CFG;
                end
            ST_GUIDE_DIAG:
                if (diag_done) state_d = ST_GUIDE_CFG;
            ST_GUIDE_CFG:
                if (cfg_done) state_d = ST_GUIDE_TEST;
            ST_GUIDE_TEST:
                if (test_done) begin
                    if (test_pass)        state_d = ST_END_OK;
                    else if (cap_reached) state_d = ST_END_FAIL;
                    else                  state_d = ST_GUIDE_DIAG;
                end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Mode flag: set when guided mode is entered, cleared on a new run.
    always_ff @(posedge clk) begin
        if (!rst_n || accept_go)
            guided_q <= 1'b0;
        else if (state_d == ST_GUIDE_DIAG)
            guided_q <= 1'b1;
    end

    // Request lines and status decoded from the state.
    always_comb begin
        cfg_req     = (state_q == ST_RAND_CFG) || (state_q == ST_GUIDE_CFG);
        cfg_partial = (state_q == ST_GUIDE_CFG);
        test_req    = (state_q == ST_RAND_TEST) || (state_q == ST_GUIDE_TEST);
        diag_req    = (state_q == ST_GUIDE_DIAG);
        map_ok      = (state_q == ST_END_OK);
        map_fail    = (state_q == ST_END_FAIL);
        busy        = !(state_q == ST_IDLE || map_ok || map_fail);
        guided      = guided_q;
    end

    // Counter and random-source strobes.
    always_comb begin
        cnt_clr   = accept_go;
        inc_total = test_fail;
        inc_rand  = test_fail && (state_q == ST_RAND_TEST);
        rng_step  = (state_d == ST_RAND_CFG || state_d == ST_GUIDE_CFG) && (state_d != state_q);
    end

    assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_req, test_req, diag_req}));
    assert_test_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !test_done) |=> test_req);
    assert_cfg_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_done) |=> (cfg_req && $stable(cfg_partial)));
    assert_rand_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAND_TEST && test_fail && !cap_reached && !budget_reached)
        |=> (cfg_req && !cfg_partial && !diag_req));
    assert_guided_diag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUIDE_TEST && test_fail && !cap_reached) |=> diag_req);
    assert_end_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (map_ok || map_fail) |-> (!busy && !(map_ok && map_fail)));
    assert_cap_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_fail && cap_reached) |=> map_fail);
endmodule

// File: rtl/selfmap_ctrl.sv
// Top of the hybrid self-mapping retry controller: sequencer, failure tally
// and random source. Assumes external units answer each request with one done pulse.
module selfmap_ctrl
    import selfmap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             seed_load,
    input  logic [15:0]      seed_val,
    input  logic [CNT_W-1:0] rand_budget,
    input  logic [CNT_W-1:0] fail_cap,
    output logic             cfg_req,
    output logic             cfg_partial,
    output logic [15:0]      cfg_rand,
    input  logic             cfg_done,
    output logic             test_req,
    input  logic             test_done,
    input  logic             test_pass,
    output logic             diag_req,
    input  logic             diag_done,
    output logic             busy,
    output logic             map_ok,
    output logic             map_fail,
    output logic             ended_guided,
    output logic [CNT_W-1:0] fail_count
);
    logic cnt_clr, inc_total, inc_rand, rng_step;
    logic cap_reached, budget_reached;
    logic seed_take;

    // Seed writes are honoured only outside a run.
    always_comb seed_take = seed_load && !busy;

    selfmap_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .go             (go),
        .cfg_done       (cfg_done),
        .test_done      (test_done),
        .test_pass      (test_pass),
        .diag_done      (diag_done),
        .cap_reached    (cap_reached),
        .budget_reached (budget_reached),
        .cfg_req        (cfg_req),
        .cfg_partial    (cfg_partial),
        .test_req       (test_req),
        .diag_req       (diag_req),
        .cnt_clr        (cnt_clr),
        .inc_total      (inc_total),
        .inc_rand       (inc_rand),
        .rng_step       (rng_step),
        .busy           (busy),
        .map_ok         (map_ok),
        .map_fail       (map_fail),
        .guided         (ended_guided)
    );

    selfmap_tally #(.CNT_W(CNT_W)) u_tally (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (cnt_clr),
        .inc_total      (inc_total),
        .inc_rand       (inc_rand),
        .cap            (fail_cap),
        .budget         (rand_budget),
        .total          (fail_count),
        .cap_reached    (cap_reached),
        .budget_reached (budget_reached)
    );

    selfmap_rng u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rng_step),
        .load  (seed_take),
        .seed  (seed_val),
        .value (cfg_rand)
    );

    assert_seed_ignored_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rng_step) |=> $stable(cfg_rand));
endmodule

// File: tb/selfmap_ctrl_test.sv
`timescale 1ns/1ps
module selfmap_ctrl_test;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0, seed_load = 1'b0;
    logic [15:0]   seed_val = '0;
    logic [CW-1:0] rand_budget = '0, fail_cap = '0;
    logic          cfg_done = 1'b0, test_done = 1'b0, test_pass = 1'b0, diag_done = 1'b0;
    logic          cfg_req, cfg_partial, test_req, diag_req;
    logic          busy, map_ok, map_fail, ended_guided;
    logic [15:0]   cfg_rand;
    logic [CW-1:0] fail_count;

    int n_checks = 0, n_fail = 0;
    logic [15:0] model = 16'hACE1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    selfmap_ctrl #(.CNT_W(CW)) uut (.*);

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_go();
        go = 1'b1; @(negedge clk); go = 1'b0;
    endtask

    // Wait for a configuration request and answer it.
    task automatic serve_cfg(input logic partial, input string req);
        int t = 0;
        while (!cfg_req && t < 50) begin @(negedge clk); t++; end
        chk({req, " cfg request seen"}, cfg_req, 1);
        chk({req, " cfg kind"}, cfg_partial, partial);
        model = nxt(model);
        chk({req, " cfg random value"}, cfg_rand, model);
        chk("R3 single request", {test_req, diag_req}, 0);
        cfg_done = 1'b1; @(negedge clk); cfg_done = 1'b0;
    endtask

    task automatic serve_test(input logic pass, input string req);
        int t = 0;
        while (!test_req && t < 50) begin @(negedge clk); t++; end
        chk({req, " test request seen"}, test_req, 1);
        chk("R4 no diagnosis with test", diag_req, 0);
        test_done = 1'b1; test_pass = pass; @(negedge clk);
        test_done = 1'b0; test_pass = 1'b0;
    endtask

    task automatic serve_diag(input string req);
        int t = 0;
        while (!diag_req && t < 50) begin @(negedge clk); t++; end
        chk({req, " diagnosis request seen"}, diag_req, 1);
        diag_done = 1'b1; @(negedge clk); diag_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 idle requests", {cfg_req, test_req, diag_req}, 0);
        chk("R1 status", {busy, map_ok, map_fail, ended_guided}, 0);
        chk("R1 fail_count", fail_count, 0);
        chk("R1 random reset", cfg_rand, 16'hACE1);
    endtask

    task automatic t_seed_then_pass();
        seed_val = 16'h1234; seed_load = 1'b1; @(negedge clk); seed_load = 1'b0;
        model = 16'h1234;
        chk("R8 seed loaded", cfg_rand, 16'h1234);
        rand_budget = 4; fail_cap = 10;
        pulse_go();
        serve_cfg(1'b0, "R2");
        serve_test(1'b1, "R6");
        chk("R6 ok", {map_ok, map_fail, busy}, 3'b100);
        chk("R6 ended random", ended_guided, 0);
        chk("R6 no failures", fail_count, 0);
    endtask

    task automatic t_switch_then_pass();
        rand_budget = 3; fail_cap = 20;
        pulse_go();
        for (int i = 0; i < 3; i++) begin
            serve_cfg(1'b0, "R4");
            serve_test(1'b0, "R4");
        end
        chk("R5 diagnosis after budget", diag_req, 1);
        chk("R7 count after random", fail_count, 3);
        serve_diag("R5");
        serve_cfg(1'b1, "R5");
        serve_test(1'b0, "R5");
        chk("R5 diagnosis again in guided", diag_req, 1);
        serve_diag("R5");
        serve_cfg(1'b1, "R5");
        serve_test(1'b1, "R6");
        chk("R6 ok guided", map_ok, 1);
        chk("R6 ended guided", ended_guided, 1);
        chk("R7 total failures", fail_count, 4);
    endtask

    task automatic t_cap_in_guided();
        rand_budget = 2; fail_cap = 3;
        pulse_go();
        chk("R9 count cleared", fail_count, 0);
        chk("R9 mode cleared", ended_guided, 0);
        serve_cfg(1'b0, "R4"); serve_test(1'b0, "R4");
        serve_cfg(1'b0, "R4"); serve_test(1'b0, "R4");
        serve_diag("R5");
        serve_cfg(1'b1, "R5");
        serve_test(1'b0, "R7");
        chk("R7 fail at cap", {map_fail, map_ok, busy}, 3'b100);
        chk("R7 fail count", fail_count, 3);
        chk("R7 ended guided", ended_guided, 1);
    endtask

    task automatic t_cap_precedes_switch();
        rand_budget = 3; fail_cap = 3;
        pulse_go();
        chk("R9 restart mode", ended_guided, 0);
        for (int i = 0; i < 3; i++) begin
            serve_cfg(1'b0, "R7"); serve_test(1'b0, "R7");
        end
        chk("R7 cap before switch", map_fail, 1);
        chk("R7 no diagnosis", diag_req, 0);
        chk("R7 ended random", ended_guided, 0);
    endtask

    task automatic t_seed_busy_and_zero();
        seed_val = 16'h0000; seed_load = 1'b1; @(negedge clk); seed_load = 1'b0;
        model = 16'h0001;
        chk("R8 zero seed", cfg_rand, 16'h0001);
        rand_budget = 0; fail_cap = 9;
        pulse_go();
        serve_cfg(1'b0, "R2");
        seed_val = 16'hBEEF; seed_load = 1'b1; @(negedge clk); seed_load = 1'b0;
        chk("R8 busy seed ignored", cfg_rand, model);
        serve_test(1'b0, "R5");
        chk("R5 zero budget diagnoses", diag_req, 1);
        serve_diag("R5");
        serve_cfg(1'b1, "R8");
        serve_test(1'b1, "R6");
        chk("R6 ok", map_ok, 1);
        chk("R7 count", fail_count, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seed_then_pass();
        t_switch_then_pass();
        t_cap_in_guided();
        t_cap_precedes_switch();
        t_seed_busy_and_zero();
        finished = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end
endmodule